// File: doc/BRIEF.md
# Gated Pulse Frame Decoder

This block recovers a conversion result that a measuring converter sends as a burst of pulses. The converter raises a frame signal for the whole measurement and lets its clock through only while that signal is high. The first 10,001 pulses of every burst come from the fixed first phase of the measurement. The pulses after them carry the value. The decoder samples the frame level and the pulse stream with its own clock, qualified by a sample enable. It counts the pulses inside one frame and, when the frame ends, reports the count less the fixed part.

A frame that runs past the longest legal length means the converter was over-ranged. The block flags this and pins the result at a saturation value. A frame too short to hold the fixed part is reported as malformed. Each decoded frame produces a single-cycle strobe. The result and both flags then hold until the next decode.

Top module: `pulse_frame_decoder`

## Requirements
- R1: A frame opens on the first enabled sample that sees `frame_i` high after a low sample. That opening sample clears the count and counts its own pulse if `pulse_i` is high.
- R2: A pulse is counted only on an enabled sample with `frame_i` high. The closing sample, where `frame_i` is seen low, never adds to the count, even if `pulse_i` is high on it.
- R3: The pulse counter holds at least 40,002 pulses. It saturates at its all-ones value and never wraps, so a very long frame still decodes as over-range.
- R4: For a total N with 10,001 ≤ N ≤ 30,002, `value_o` = N − 10,001 (0 to 20,001) and both flags are 0.
- R5: For N > 30,002, `overrange_o` = 1, `malformed_o` = 0 and `value_o` = 20,000.
- R6: For N < 10,001 (including zero pulses), `malformed_o` = 1, `overrange_o` = 0 and `value_o` = 0.
- R7: `done_o` is high for exactly one clock, in the cycle after the closing sample. `value_o`, `overrange_o` and `malformed_o` change only together with `done_o` and hold their values otherwise.
- R8: After reset, `done_o`, `value_o`, `overrange_o` and `malformed_o` are all 0.
- R9: Every frame starts from a zero count. A frame that opens right after a closing sample ignores the earlier frame's pulses.
- R10: While `sample_en` is low, a change on `frame_i` is not seen as an edge, pulses are not counted and no decode happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Qualifies a sample of `frame_i` and `pulse_i` |
| frame_i | input | 1 | Frame level from the converter |
| pulse_i | input | 1 | High for one sample per gated pulse |
| done_o | output | 1 | One-cycle strobe: a frame was decoded |
| value_o | output | 15 | Decoded result |
| overrange_o | output | 1 | Frame longer than the legal maximum |
| malformed_o | output | 1 | Frame shorter than the fixed first phase |

## Verification
A decode and the opening of the next frame can fall in the same cycle. When `frame_i` drops for a single enabled sample and then rises again with a pulse on it, the strobe for the old frame comes out in the same cycle as the first sample of the new frame is counted. The bench provokes this by running two frames back to back, and puts a pulse on the closing sample as well. The scoreboard then requires the old frame's value to be exact. It also requires the new frame's value to match its own pulse count, with no leftover from the frame before it.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Frame classification: a long frame wins over every other outcome.
  function automatic bit pfd_is_over(int unsigned total, int unsigned over_total);
    return total > over_total;
  endfunction

  function automatic bit pfd_is_short(int unsigned total, int unsigned offset,
                                      int unsigned over_total);
    return (total < offset) && !(total > over_total);
  endfunction

  // Decoded value for a frame total.
  function automatic int unsigned pfd_value(int unsigned total, int unsigned offset,
                                            int unsigned over_total, int unsigned sat);
    if (total > over_total) return sat;
    if (total < offset) return 0;
    return total - offset;
  endfunction

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  input  logic frame_i,
  output logic open_o,
  output logic close_o,
  output logic inside_o
);
  logic frame_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         frame_q <= 1'b0;
    else if (sample_en) frame_q <= frame_i;
  end

  assign open_o   = sample_en &  frame_i & ~frame_q;
  assign close_o  = sample_en & ~frame_i &  frame_q;
  assign inside_o = sample_en &  frame_i &  frame_q;
endmodule

// File: rtl/pfd_counter.sv
module pfd_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic             step_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (open_i)
      cnt_q <= {{(CNT_W-1){1'b0}}, pulse_i};
    else if (step_i && pulse_i && cnt_q != CNT_TOP)
      cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/pfd_decode.sv
module pfd_decode
  import pfd_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RES_W      = 15,
  parameter int OFFSET     = 10001,
  parameter int OVER_TOTAL = 30002,
  parameter int SAT_VALUE  = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             done_o,
  output logic [RES_W-1:0] value_o,
  output logic             over_o,
  output logic             short_o
);
  logic [31:0] total;
  assign total = 32'(count_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o  <= 1'b0;
      value_o <= '0;
      over_o  <= 1'b0;
      short_o <= 1'b0;
    end else begin
      done_o <= close_i;
      if (close_i) begin
        value_o <= RES_W'(pfd_value(total, OFFSET, OVER_TOTAL, SAT_VALUE));
        over_o  <= pfd_is_over(total, OVER_TOTAL);
        short_o <= pfd_is_short(total, OFFSET, OVER_TOTAL);
      end
    end
  end
endmodule

// File: rtl/pulse_frame_decoder.sv
module pulse_frame_decoder #(
  parameter int OFFSET     = 10001,
  parameter int OVER_TOTAL = 30002,
  parameter int SAT_VALUE  = 20000,
  parameter int MIN_CAP    = 40002,
  localparam int CNT_W     = $clog2(MIN_CAP + 1),
  localparam int RES_W     = $clog2(OVER_TOTAL - OFFSET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             frame_i,
  input  logic             pulse_i,
  output logic             done_o,
  output logic [RES_W-1:0] value_o,
  output logic             overrange_o,
  output logic             malformed_o
);
  // Internal events, named for the checker.
  logic             frame_open;
  logic             frame_close;
  logic             frame_inside;
  logic [CNT_W-1:0] pulse_count;

  pfd_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_en(sample_en),
    .frame_i  (frame_i),
    .open_o   (frame_open),
    .close_o  (frame_close),
    .inside_o (frame_inside)
  );

  pfd_counter #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (frame_open),
    .step_i (frame_inside),
    .pulse_i(pulse_i),
    .count_o(pulse_count)
  );

  pfd_decode #(
    .CNT_W     (CNT_W),
    .RES_W     (RES_W),
    .OFFSET    (OFFSET),
    .OVER_TOTAL(OVER_TOTAL),
    .SAT_VALUE (SAT_VALUE)
  ) u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .close_i(frame_close),
    .count_i(pulse_count),
    .done_o (done_o),
    .value_o(value_o),
    .over_o (overrange_o),
    .short_o(malformed_o)
  );
endmodule

// File: rtl/pfd_checks.sv
module pfd_checks #(
  parameter int CNT_W      = 16,
  parameter int RES_W      = 15,
  parameter int OFFSET     = 10001,
  parameter int OVER_TOTAL = 30002,
  parameter int SAT_VALUE  = 20000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_en,
  input logic             pulse_i,
  input logic             frame_close,
  input logic             frame_inside,
  input logic [CNT_W-1:0] pulse_count,
  input logic             done_o,
  input logic [RES_W-1:0] value_o,
  input logic             overrange_o,
  input logic             malformed_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  // R3: counting steps by one inside a frame
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_inside && pulse_i && pulse_count != CNT_TOP)
      |=> pulse_count == CNT_W'($past(pulse_count) + 1'b1));

  // R3: a full counter stays full
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_inside && pulse_count == CNT_TOP) |=> pulse_count == CNT_TOP);

  // R5: over-range pins the value
  p_over_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && overrange_o) |-> value_o == RES_W'(SAT_VALUE));

  // R6: short frame reports zero
  p_short_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && malformed_o) |-> value_o == '0);

  // R4: legal value range
  p_value_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !overrange_o) |-> 32'(value_o) <= 32'(OVER_TOTAL - OFFSET));

  // R5/R6: flags never both set
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(overrange_o && malformed_o));

  // R7: strobe follows the closing sample and lasts one cycle
  p_done_after_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_close |=> done_o);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_close |=> ($stable(value_o) && $stable(overrange_o) && $stable(malformed_o)));

  // R10: a disabled sample decodes nothing
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> !done_o);
endmodule

bind pulse_frame_decoder pfd_checks #(
  .CNT_W     (CNT_W),
  .RES_W     (RES_W),
  .OFFSET    (OFFSET),
  .OVER_TOTAL(OVER_TOTAL),
  .SAT_VALUE (SAT_VALUE)
) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_en   (sample_en),
  .pulse_i     (pulse_i),
  .frame_close (frame_close),
  .frame_inside(frame_inside),
  .pulse_count (pulse_count),
  .done_o      (done_o),
  .value_o     (value_o),
  .overrange_o (overrange_o),
  .malformed_o (malformed_o)
);

// File: tb/pulse_frame_decoder_bench.sv
module pulse_frame_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_en = 1'b0;
  logic        frame_i = 1'b0;
  logic        pulse_i = 1'b0;
  logic        done_o;
  logic [14:0] value_o;
  logic        overrange_o;
  logic        malformed_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int    val;
    bit    ovr;
    bit    bad;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_frame_decoder u_pulse_frame_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_en  (sample_en),
    .frame_i    (frame_i),
    .pulse_i    (pulse_i),
    .done_o     (done_o),
    .value_o    (value_o),
    .overrange_o(overrange_o),
    .malformed_o(malformed_o)
  );

  task automatic check(bit ok, string tag, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Expected outcome restated from the requirements.
  function automatic exp_t expect_for(int total, string tag);
    exp_t e;
    e.tag = tag;
    e.ovr = 1'b0;
    e.bad = 1'b0;
    if (total >= 30003)      begin e.ovr = 1'b1; e.val = 20000; end
    else if (total <= 10000) begin e.bad = 1'b1; e.val = 0;     end
    else                     e.val = total - 10001;
    return e;
  endfunction

  // Driver: n counted pulses (gated: a disabled sample with frame low and a
  // pulse between them), quiet frame-high samples, a closing sample with a
  // pulse on it, then gap idle samples.
  task automatic run_frame(int n, bit gated, int quiet, int gap, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sample_en = 1'b1; frame_i = 1'b1; pulse_i = 1'b1;
      if (gated && i < n - 1) begin
        @(negedge clk); sample_en = 1'b0; frame_i = 1'b0; pulse_i = 1'b1;
      end
    end
    for (int i = 0; i < quiet; i++) begin
      @(negedge clk); sample_en = 1'b1; frame_i = 1'b1; pulse_i = 1'b0;
    end
    exp_q.push_back(expect_for(n, tag));
    @(negedge clk); sample_en = 1'b1; frame_i = 1'b0; pulse_i = 1'b1;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk); sample_en = 1'b1; frame_i = 1'b0; pulse_i = 1'b0;
    end
  endtask

  // Monitor: compare each decode with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected decode", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(value_o) == e.val, {e.tag, " value"}, int'(value_o), e.val);
        check(overrange_o == e.ovr, {e.tag, " overrange"}, int'(overrange_o), int'(e.ovr));
        check(malformed_o == e.bad, {e.tag, " malformed"}, int'(malformed_o), int'(e.bad));
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(done_o == 1'b0, "R8 done after reset", int'(done_o), 0);
    check(value_o == '0, "R8 value after reset", int'(value_o), 0);
    check(overrange_o == 1'b0, "R8 overrange after reset", int'(overrange_o), 0);
    check(malformed_o == 1'b0, "R8 malformed after reset", int'(malformed_o), 0);

    run_frame(5, 1'b0, 0, 3, "R1 R6 short frame of 5");
    run_frame(10001, 1'b1, 0, 2, "R4 R10 gated frame of 10001");
    run_frame(10000, 1'b0, 0, 0, "R6 frame of 10000");
    run_frame(12345, 1'b0, 2, 2, "R9 R2 back-to-back frame");
    run_frame(0, 1'b0, 4, 2, "R6 empty frame");
    run_frame(30002, 1'b0, 0, 2, "R4 longest legal frame");
    run_frame(30003, 1'b0, 0, 2, "R5 over-range frame");
    run_frame(66000, 1'b0, 0, 2, "R3 R5 frame past counter top");

    // R10: disabled samples with frame and pulse activity decode nothing
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); sample_en = 1'b0; frame_i = 1'b1; pulse_i = 1'b1;
    end
    @(negedge clk); sample_en = 1'b0; frame_i = 1'b0; pulse_i = 1'b0;
    repeat (4) @(negedge clk);
    check(int'(value_o) == 20000, "R7 R10 value held", int'(value_o), 20000);
    check(overrange_o == 1'b1, "R7 R10 overrange held", int'(overrange_o), 1);
    check(done_o == 1'b0, "R10 no decode while disabled", int'(done_o), 0);
    check(exp_q.size() == 0, "R7 every frame decoded", exp_q.size(), 0);
    summary();
  end
endmodule